// File: doc/BRIEF.md
# Ping-Pong Bulk Receive Packet Buffer

This block sits between the byte stream delivered by a USB serial interface engine for a bulk-out endpoint and a local microcontroller that drains the received packets. It holds two equal banks of storage. The protocol side writes one packet into the current fill bank, and an end-of-packet pulse closes that bank. The microcontroller reads the closed bank byte by byte through a read strobe. While it reads, the next packet streams into the other bank, so up to two full packets can be held at once.

A packet-ready status bit and a level interrupt tell the microcontroller that a closed bank is waiting. The microcontroller releases a drained bank by writing a one to the ready bit. The release always frees the drained bank and moves the read side to the other bank. If that other bank already holds a closed packet, the ready bit and the interrupt do not drop. This lets firmware drain packets back to back without missing one.

A configuration input selects single-bank operation. In that mode only bank A is used, and the protocol side is held off until the bank is released. When no bank is free to fill, a busy flag tells the protocol engine to refuse the packet.

Top module: `bulk_rx_pingpong`

## Requirements
- R1: Each bank stores at most BANK_DEPTH (default 64) bytes. Bytes beyond that in one packet are dropped. The byte count of a bank is latched at end of packet and saturates at BANK_DEPTH. `rd_count` shows the count of the bank currently being read.
- R2: An end-of-packet pulse accepted while `rx_busy` is low raises `pkt_ready` and `irq` on the next clock. `irq` always equals `pkt_ready`.
- R3: With `dbl_en` high, the packet after a closed one is written into the other bank while the first bank is read. `rd_data` presents the bytes of the read bank in arrival order. Each `rd_stb` while `pkt_ready` is high advances to the next byte one clock later.
- R4: A release is a cycle with `stat_wr` high and `stat_wdata` equal to 1. A write with `stat_wdata` equal to 0 leaves `pkt_ready`, `irq` and `rd_count` unchanged.
- R5: A release while `pkt_ready` is high lowers `pkt_ready` and `irq` on the next clock when the other bank holds no closed packet and is not closing one in that same cycle.
- R6: With `dbl_en` high, a release while the other bank holds a closed packet, or closes one in that same cycle, keeps `pkt_ready` and `irq` high. The drained bank is still freed, and the read side moves to the other bank, whose length then appears on `rd_count`.
- R7: Both orderings deliver every packet intact: the second bank closes before the first is drained, or the first is drained and released before the second closes.
- R8: With `dbl_en` low, only bank A is used. After a packet closes, `rx_busy` stays high until the release. `dbl_en` is changed only while both banks are empty.
- R9: `rx_busy` is high exactly when the current fill bank holds a closed packet. While it is high, incoming bytes and end-of-packet pulses are ignored.
- R10: A synchronous reset empties both banks, points the fill and read sides at bank A, clears the counts, and drives `pkt_ready`, `irq` and `rx_busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dbl_en | input | 1 | 1 = two-bank operation, 0 = bank A only |
| in_valid | input | 1 | Receive byte strobe from the protocol engine |
| in_data | input | DATA_W | Receive byte |
| in_eop | input | 1 | End of packet; may coincide with the last byte |
| rx_busy | output | 1 | No free bank to fill; protocol engine answers NAK |
| rd_stb | input | 1 | Advance to the next byte of the read bank |
| rd_data | output | DATA_W | Current byte of the read bank |
| rd_count | output | CW | Latched byte count of the read bank |
| stat_wr | input | 1 | Write strobe for the packet-ready bit |
| stat_wdata | input | 1 | Value written; 1 requests release |
| pkt_ready | output | 1 | A closed packet waits in the read bank |
| irq | output | 1 | Interrupt, active high, follows pkt_ready |

## Verification
Every status output (`pkt_ready`, `irq`, `rx_busy`, `rd_count`) is due one clock after the rising edge that captures the stimulus. `rd_data` follows the registered read pointer with no further delay, so the byte after a read strobe is present one clock after the strobe. The bench changes inputs on falling edges and samples on the next falling edge. Each result is therefore read half a period after the edge that produced it, and never at an edge. A release that meets an end of packet in the same cycle is sampled at that one edge, to show that the ready bit never dips.

// File: rtl/bulk_rx_pkg.sv
package bulk_rx_pkg;

    localparam int NUM_BANKS = 2;

    typedef enum logic {
        BANK_A = 1'b0,
        BANK_B = 1'b1
    } bank_e;

    function automatic bank_e other_bank(input bank_e b);
        return bank_e'(~b);
    endfunction

endpackage

// File: rtl/rx_bank_mem.sv
module rx_bank_mem #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/rx_fill_ctrl.sv
module rx_fill_ctrl
    import bulk_rx_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 dbl_en,
    input  logic                 in_valid,
    input  logic                 in_eop,
    input  logic [NUM_BANKS-1:0] bank_full,
    output bank_e                fill_sel,
    output logic                 wr_en,
    output logic [AW-1:0]        wr_addr,
    output logic [NUM_BANKS-1:0] done,
    output logic [CW-1:0]        done_cnt,
    output logic                 busy
);

    typedef struct packed {
        bank_e         sel;
        logic [CW-1:0] wr_ptr;
    } fill_st_t;

    fill_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        wr_en    = 1'b0;
        done     = '0;
        done_cnt = st_q.wr_ptr;
        if (!bank_full[st_q.sel]) begin
            if (in_valid && (st_q.wr_ptr < CW'(DEPTH))) begin
                wr_en       = 1'b1;
                st_d.wr_ptr = st_q.wr_ptr + 1'b1;
            end
            if (in_eop) begin
                done[st_q.sel] = 1'b1;
                done_cnt       = st_d.wr_ptr;
                st_d.wr_ptr    = '0;
                if (dbl_en) begin
                    st_d.sel = other_bank(st_q.sel);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{sel: BANK_A, wr_ptr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign fill_sel = st_q.sel;
    assign wr_addr  = st_q.wr_ptr[AW-1:0];
    assign busy     = bank_full[st_q.sel];

endmodule

// File: rtl/rx_drain_ctrl.sv
module rx_drain_ctrl
    import bulk_rx_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 dbl_en,
    input  logic [NUM_BANKS-1:0] done,
    input  logic [CW-1:0]        done_cnt,
    input  logic                 rd_stb,
    input  logic                 clr_req,
    output logic [NUM_BANKS-1:0] bank_full,
    output bank_e                read_sel,
    output logic [AW-1:0]        rd_addr,
    output logic [CW-1:0]        rd_count,
    output logic                 pkt_ready
);

    typedef struct packed {
        logic [NUM_BANKS-1:0]         full;
        logic [NUM_BANKS-1:0][CW-1:0] cnt;
        bank_e                        rsel;
        logic [AW-1:0]                rd_ptr;
    } drain_st_t;

    drain_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (done[b]) begin
                st_d.full[b] = 1'b1;
                st_d.cnt[b]  = done_cnt;
            end
        end
        if (rd_stb && st_q.full[st_q.rsel] && (st_q.rd_ptr != AW'(DEPTH - 1))) begin
            st_d.rd_ptr = st_q.rd_ptr + 1'b1;
        end
        if (clr_req && st_q.full[st_q.rsel]) begin
            st_d.full[st_q.rsel] = 1'b0;
            st_d.rd_ptr          = '0;
            if (dbl_en) begin
                st_d.rsel = other_bank(st_q.rsel);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bank_full = st_q.full;
    assign read_sel  = st_q.rsel;
    assign rd_addr   = st_q.rd_ptr;
    assign rd_count  = st_q.cnt[st_q.rsel];
    assign pkt_ready = st_q.full[st_q.rsel];

endmodule

// File: rtl/bulk_rx_pingpong.sv
module bulk_rx_pingpong
    import bulk_rx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int BANK_DEPTH = 64,
    localparam int AW        = $clog2(BANK_DEPTH),
    localparam int CW        = $clog2(BANK_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dbl_en,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_eop,
    output logic              rx_busy,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data,
    output logic [CW-1:0]     rd_count,
    input  logic              stat_wr,
    input  logic              stat_wdata,
    output logic              pkt_ready,
    output logic              irq
);

    logic [NUM_BANKS-1:0] bank_full;
    logic [NUM_BANKS-1:0] done;
    logic [CW-1:0]        done_cnt;
    bank_e                fill_sel;
    bank_e                read_sel;
    logic                 wr_en;
    logic [AW-1:0]        wr_addr;
    logic [AW-1:0]        rd_addr;
    logic                 clr_req;
    logic [DATA_W-1:0]    bank_rdata [NUM_BANKS];

    assign clr_req = stat_wr && stat_wdata;

    rx_fill_ctrl #(.DEPTH(BANK_DEPTH)) u_fill (
        .clk       (clk),
        .rst       (rst),
        .dbl_en    (dbl_en),
        .in_valid  (in_valid),
        .in_eop    (in_eop),
        .bank_full (bank_full),
        .fill_sel  (fill_sel),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .done      (done),
        .done_cnt  (done_cnt),
        .busy      (rx_busy)
    );

    rx_drain_ctrl #(.DEPTH(BANK_DEPTH)) u_drain (
        .clk       (clk),
        .rst       (rst),
        .dbl_en    (dbl_en),
        .done      (done),
        .done_cnt  (done_cnt),
        .rd_stb    (rd_stb),
        .clr_req   (clr_req),
        .bank_full (bank_full),
        .read_sel  (read_sel),
        .rd_addr   (rd_addr),
        .rd_count  (rd_count),
        .pkt_ready (pkt_ready)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        rx_bank_mem #(.DATA_W(DATA_W), .DEPTH(BANK_DEPTH)) u_mem (
            .clk   (clk),
            .we    (wr_en && (fill_sel == bank_e'(1'(b)))),
            .waddr (wr_addr),
            .wdata (in_data),
            .raddr (rd_addr),
            .rdata (bank_rdata[b])
        );
    end

    assign rd_data = bank_rdata[read_sel];
    assign irq     = pkt_ready;

endmodule

// File: rtl/bulk_rx_pingpong_chk.sv
module bulk_rx_pingpong_chk #(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          dbl_en,
    input logic          in_eop,
    input logic          stat_wr,
    input logic          stat_wdata,
    input logic          rx_busy,
    input logic          pkt_ready,
    input logic          irq,
    input logic [CW-1:0] rd_count,
    input logic [1:0]    bank_full,
    input logic          read_sel
);

    logic other_full;
    logic other_closing;
    assign other_full    = bank_full[~read_sel];
    assign other_closing = in_eop && !rx_busy;

    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        rd_count <= CW'(DEPTH)); // R1

    AST_READY_AFTER_EOP: assert property (@(posedge clk) disable iff (rst)
        (in_eop && !rx_busy) |=> (pkt_ready && irq)); // R2

    AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && !stat_wdata && pkt_ready) |=> pkt_ready); // R4

    AST_CLEAR_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && stat_wdata && pkt_ready && !(dbl_en && (other_full || other_closing)))
        |=> (!pkt_ready && !irq)); // R5

    AST_CLEAR_REFUSED: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && stat_wdata && pkt_ready && dbl_en && (other_full || other_closing))
        |=> (pkt_ready && irq)); // R6

    AST_SINGLE_HOLDS_OFF: assert property (@(posedge clk) disable iff (rst)
        (!dbl_en && pkt_ready) |-> rx_busy); // R8

    AST_BOTH_FULL_BUSY: assert property (@(posedge clk) disable iff (rst)
        (&bank_full) |-> rx_busy); // R9

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pkt_ready && !irq && !rx_busy && rd_count == '0)); // R10

endmodule

bind bulk_rx_pingpong bulk_rx_pingpong_chk #(.DEPTH(BANK_DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .dbl_en     (dbl_en),
    .in_eop     (in_eop),
    .stat_wr    (stat_wr),
    .stat_wdata (stat_wdata),
    .rx_busy    (rx_busy),
    .pkt_ready  (pkt_ready),
    .irq        (irq),
    .rd_count   (rd_count),
    .bank_full  (bank_full),
    .read_sel   (read_sel)
);

// File: tb/bulk_rx_pingpong_bench.sv
module bulk_rx_pingpong_bench;

    localparam int DW = 8;
    localparam int DEPTH = 64;
    localparam int CW = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          dbl_en = 1'b1;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_eop = 1'b0;
    logic          rx_busy;
    logic          rd_stb = 1'b0;
    logic [DW-1:0] rd_data;
    logic [CW-1:0] rd_count;
    logic          stat_wr = 1'b0;
    logic          stat_wdata = 1'b0;
    logic          pkt_ready;
    logic          irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    bulk_rx_pingpong #(.DATA_W(DW), .BANK_DEPTH(DEPTH)) u_bulk_rx_pingpong (
        .clk(clk), .rst(rst), .dbl_en(dbl_en), .in_valid(in_valid),
        .in_data(in_data), .in_eop(in_eop), .rx_busy(rx_busy),
        .rd_stb(rd_stb), .rd_data(rd_data), .rd_count(rd_count),
        .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .pkt_ready(pkt_ready), .irq(irq)
    );

    // op: 0 send packet, 1 drain and compare bytes, 2 release
    typedef struct packed {
        logic [1:0] op;
        logic [7:0] len;
        logic [7:0] seed;
        logic       exp_rdy;
        logic       exp_busy;
        logic [7:0] exp_cnt; // 255 = not compared
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 8'd10, 8'h10, 1'b1, 1'b0, 8'd10},
        '{2'd0, 8'd20, 8'h40, 1'b1, 1'b1, 8'd10},
        '{2'd0, 8'd5,  8'hEE, 1'b1, 1'b1, 8'd10},
        '{2'd1, 8'd10, 8'h10, 1'b1, 1'b1, 8'd10},
        '{2'd2, 8'd0,  8'h00, 1'b1, 1'b0, 8'd20},
        '{2'd1, 8'd20, 8'h40, 1'b1, 1'b0, 8'd20},
        '{2'd2, 8'd0,  8'h00, 1'b0, 1'b0, 8'd255},
        '{2'd0, 8'd64, 8'h80, 1'b1, 1'b0, 8'd64},
        '{2'd1, 8'd64, 8'h80, 1'b1, 1'b0, 8'd64},
        '{2'd2, 8'd0,  8'h00, 1'b0, 1'b0, 8'd255},
        '{2'd0, 8'd70, 8'h00, 1'b1, 1'b0, 8'd64},
        '{2'd1, 8'd64, 8'h00, 1'b1, 1'b0, 8'd64},
        '{2'd2, 8'd0,  8'h00, 1'b0, 1'b0, 8'd255}
    };

    function automatic string row_tag(input int i);
        case (i)
            0:       return "R2";
            1, 2:    return "R9";
            3, 8:    return "R3";
            4:       return "R6";
            5, 7:    return "R7";
            10, 11:  return "R1";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_status(input string req, input logic rdy, input logic busy, input logic [7:0] cnt);
        chk(req, 32'(pkt_ready), 32'(rdy));
        chk(req, 32'(irq), 32'(rdy));
        chk(req, 32'(rx_busy), 32'(busy));
        if (cnt != 8'd255) chk(req, 32'(rd_count), 32'(cnt));
    endtask

    // all tasks start and end just after a falling edge
    task automatic send_pkt(input int n, input logic [7:0] seed, input logic clr_at_eop);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_data  = 8'(seed + 8'(i));
            in_eop   = (i == n - 1);
            if (clr_at_eop && i == n - 1) begin
                stat_wr    = 1'b1;
                stat_wdata = 1'b1;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_eop   = 1'b0;
        stat_wr  = 1'b0;
    endtask

    task automatic drain(input int n, input logic [7:0] seed, input string req);
        for (int i = 0; i < n; i++) begin
            chk(req, 32'(rd_data), 32'(8'(seed + 8'(i))));
            rd_stb = 1'b1;
            @(negedge clk);
        end
        rd_stb = 1'b0;
    endtask

    task automatic status_write(input logic val);
        stat_wr    = 1'b1;
        stat_wdata = val;
        @(negedge clk);
        stat_wr    = 1'b0;
        stat_wdata = 1'b0;
    endtask

    task automatic do_reset(input logic dbl);
        rst    = 1'b1;
        dbl_en = dbl;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        do_reset(1'b1);
        chk_status("R10 initial", 1'b0, 1'b0, 8'd0);

        for (int v = 0; v < NV; v++) begin
            case (VECS[v].op)
                2'd0:    send_pkt(int'(VECS[v].len), VECS[v].seed, 1'b0);
                2'd1:    drain(int'(VECS[v].len), VECS[v].seed, row_tag(v));
                default: status_write(1'b1);
            endcase
            chk_status(row_tag(v), VECS[v].exp_rdy, VECS[v].exp_busy, VECS[v].exp_cnt);
        end

        // R4: writing zero to the ready bit is ignored
        send_pkt(5, 8'h22, 1'b0);
        status_write(1'b0);
        chk_status("R4", 1'b1, 1'b0, 8'd5);

        // R6: release meets end of packet in the other bank in the same cycle
        send_pkt(7, 8'h33, 1'b1);
        chk_status("R6 same-cycle", 1'b1, 1'b0, 8'd7);
        drain(7, 8'h33, "R6");
        status_write(1'b1);
        chk_status("R5 after same-cycle", 1'b0, 1'b0, 8'd255);

        // R10: reset in the middle of traffic
        send_pkt(3, 8'h01, 1'b0);
        do_reset(1'b1);
        chk_status("R10 mid-run", 1'b0, 1'b0, 8'd0);

        // R8: single-bank mode
        do_reset(1'b0);
        send_pkt(8, 8'h50, 1'b0);
        chk_status("R8 closed", 1'b1, 1'b1, 8'd8);
        send_pkt(3, 8'h99, 1'b0);
        chk_status("R8 held off", 1'b1, 1'b1, 8'd8);
        drain(8, 8'h50, "R8");
        status_write(1'b1);
        chk_status("R8 released", 1'b0, 1'b0, 8'd255);
        send_pkt(4, 8'h60, 1'b0);
        chk_status("R8 reuse", 1'b1, 1'b1, 8'd4);
        drain(4, 8'h60, "R8");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule